// File: doc/BRIEF.md
# Page Table Entry Check Unit

This block judges a single page table entry that an address-translation walker has just read from memory. It takes the raw 64-bit entry with the translation scheme in force (32-bit two-level, 39-bit three-level or 48-bit four-level), the kind of access being translated, the privilege of the requester and the two status controls that widen access: executable-readable and supervisor-may-touch-user. From these it decides whether the entry is broken, whether it points to a lower table, or whether it is a leaf that grants or denies the access.

For a leaf that grants the access, the unit also produces the entry with its accessed and dirty flags brought up to date. It raises a write-back request only when one of those two flags actually changes. It also splits out the physical page number and the upper reserved field according to the scheme. A walker drives requests in through a valid/ready pair and takes each verdict from one registered output stage, one cycle after the request is accepted.

Top module: `pte_check_unit`

## Requirements
- R1: Flag byte positions are V=bit0, R=bit1, W=bit2, X=bit3, U=bit4, G=bit5, A=bit6, D=bit7 in every scheme. If V=0, or if W=1 with R=0, the entry is broken and pageFault is set. A non-broken entry with R, W and X all zero sets isPointer and does not fault. Every other non-broken entry is a leaf.
- R2: modeSel encoding is 0 for the 32-bit scheme, 1 for the 39-bit scheme, and 2 or 3 for the 48-bit scheme. In the 32-bit scheme, ppnOut is entry bits 31..10, zero-extended, and upperOut is zero. In the other schemes, ppnOut is bits 53..10 and upperOut is bits 63..54.
- R3: For privLvl 0 (user), the access kind is encoded as 0 read, 1 write, 2 read-modify-write, 3 execute. The entry always needs U=1. Readability means R=1, or X=1 with mxrBit=1. A read needs readability, a write needs W=1, a read-modify-write needs W=1 and readability, and an execute needs X=1. A leaf that fails these rules sets pageFault.
- R4: For privLvl 1 (supervisor), read, write and read-modify-write follow the same R/W/X rules as in R3, but the U condition becomes U=0 or sumBit=1.
- R5: A supervisor execute needs U=0 and X=1, whatever the value of sumBit.
- R6: privLvl 2 or 3 (machine) sets internalErr and forces pageFault and needWriteback low.
- R7: needWriteback is set only for a leaf that passes its check and has A=0, or has D=0 with a write or read-modify-write. When it is set, entryOut has bit 6 set, and also bit 7 if the access writes. Otherwise entryOut equals the input entry. Bits 63..8 are always carried over unchanged.
- R8: inReady equals !outValid || outReady. An accepted request shows on the outputs with outValid=1 in the next cycle. The outputs hold steady while outValid=1 and outReady=0.
- R9: While rstN is low and after reset releases, outValid is 0 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken this cycle |
| entryIn | input | 64 | Raw page table entry |
| modeSel | input | 2 | Translation scheme (0: 32-bit, 1: 39-bit, 2/3: 48-bit) |
| accKind | input | 2 | Access kind (0 read, 1 write, 2 read-modify-write, 3 execute) |
| privLvl | input | 2 | Requester privilege (0 user, 1 supervisor, 2/3 machine) |
| mxrBit | input | 1 | Executable pages also readable |
| sumBit | input | 1 | Supervisor may access user pages |
| outValid | output | 1 | Verdict present |
| outReady | input | 1 | Consumer takes the verdict |
| pageFault | output | 1 | Entry broken or access denied |
| isPointer | output | 1 | Entry points to the next table level |
| needWriteback | output | 1 | Updated entry must be written back |
| internalErr | output | 1 | Machine-privilege request reached the check |
| entryOut | output | 64 | Entry with accessed/dirty flags updated |
| ppnOut | output | 44 | Physical page number for the scheme |
| upperOut | output | 10 | Upper reserved field (zero in the 32-bit scheme) |

## Verification
The assertions assume that inputs are stable whenever they are sampled at a rising edge while inValid is high. They also assume that the consumer keeps outReady meaningful in every cycle, so that stall and hold behaviour can be judged. The bench changes inputs only a short time after the falling edge. It stalls the output side with a varied pattern of outReady, and it sweeps every privilege and access encoding, including the machine encodings, across all three schemes and random entries. As a result, each assertion sees both granted and denied leaves as well as held outputs.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;
  localparam int FLAG_W  = 8;
  localparam int FLG_V   = 0;
  localparam int FLG_R   = 1;
  localparam int FLG_W   = 2;
  localparam int FLG_X   = 3;
  localparam int FLG_U   = 4;
  localparam int FLG_A   = 6;
  localparam int FLG_D   = 7;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_RMW = 2'd2,
    ACC_EX  = 2'd3
  } accKind_e;

  typedef enum logic [1:0] {
    PRV_USER = 2'd0,
    PRV_SUP  = 2'd1,
    PRV_M2   = 2'd2,
    PRV_M3   = 2'd3
  } privLvl_e;

  typedef struct packed {
    logic loadOut;
  } ctrlStrobe_t;
endpackage

// File: rtl/pte_chk_ctrl.sv
module pte_chk_ctrl
  import pte_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);
  logic validQ;

  assign inReady        = !validQ || outReady;
  assign strobe.loadOut = inValid && inReady;
  assign outValid       = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.loadOut) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end
endmodule

// File: rtl/pte_chk_dp.sv
module pte_chk_dp
  import pte_chk_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int UPPER_W = 10,
  parameter int PPN_LSB = 10,
  parameter int NARROW_W = 32,
  localparam int PPN_W = ENTRY_W - UPPER_W - PPN_LSB,
  localparam int NARROW_PPN_W = NARROW_W - PPN_LSB
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [ENTRY_W-1:0] entryIn,
  input  logic [1:0]         modeSel,
  input  logic [1:0]         accKind,
  input  logic [1:0]         privLvl,
  input  logic               mxrBit,
  input  logic               sumBit,
  output logic               pageFault,
  output logic               isPointer,
  output logic               needWriteback,
  output logic               internalErr,
  output logic [ENTRY_W-1:0] entryOut,
  output logic [PPN_W-1:0]   ppnOut,
  output logic [UPPER_W-1:0] upperOut
);
  logic fV, fR, fW, fX, fU, fA, fD;
  logic badEntry, ptrEntry, leafEntry, readable, machineReq, userReq;
  logic permBase, ownerOk, permOk, writesAcc, setA, setD;
  logic faultC, wbC;
  logic [ENTRY_W-1:0] newEntry;
  logic [PPN_W-1:0]   ppnC;
  logic [UPPER_W-1:0] upperC;

  assign fV = entryIn[FLG_V];
  assign fR = entryIn[FLG_R];
  assign fW = entryIn[FLG_W];
  assign fX = entryIn[FLG_X];
  assign fU = entryIn[FLG_U];
  assign fA = entryIn[FLG_A];
  assign fD = entryIn[FLG_D];

  assign badEntry   = !fV || (fW && !fR);
  assign ptrEntry   = !badEntry && !(fR || fW || fX);
  assign leafEntry  = !badEntry && !ptrEntry;
  assign readable   = fR || (fX && mxrBit);
  assign machineReq = privLvl[1];
  assign userReq    = (privLvl == PRV_USER);
  assign writesAcc  = (accKind == ACC_WR) || (accKind == ACC_RMW);

  always_comb begin
    unique case (accKind)
      ACC_RD:  permBase = readable;
      ACC_WR:  permBase = fW;
      ACC_RMW: permBase = fW && readable;
      default: permBase = fX;
    endcase
    if (userReq)                    ownerOk = fU;
    else if (accKind == ACC_EX)     ownerOk = !fU;
    else                            ownerOk = !fU || sumBit;
  end

  assign permOk = ownerOk && permBase;
  assign faultC = !machineReq && (badEntry || (leafEntry && !permOk));
  assign setA   = !fA;
  assign setD   = !fD && writesAcc;
  assign wbC    = leafEntry && !machineReq && permOk && (setA || setD);

  always_comb begin
    newEntry = entryIn;
    if (wbC) begin
      newEntry[FLG_A] = 1'b1;
      if (writesAcc) newEntry[FLG_D] = 1'b1;
    end
  end

  always_comb begin
    if (modeSel == 2'd0) begin
      ppnC   = {{(PPN_W-NARROW_PPN_W){1'b0}}, entryIn[NARROW_W-1:PPN_LSB]};
      upperC = '0;
    end else begin
      ppnC   = entryIn[PPN_LSB +: PPN_W];
      upperC = entryIn[ENTRY_W-1 -: UPPER_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageFault     <= 1'b0;
      isPointer     <= 1'b0;
      needWriteback <= 1'b0;
      internalErr   <= 1'b0;
      entryOut      <= '0;
      ppnOut        <= '0;
      upperOut      <= '0;
    end else if (strobe.loadOut) begin
      pageFault     <= faultC;
      isPointer     <= ptrEntry;
      needWriteback <= wbC;
      internalErr   <= machineReq;
      entryOut      <= newEntry;
      ppnOut        <= ppnC;
      upperOut      <= upperC;
    end
  end
endmodule

// File: rtl/pte_check_unit.sv
module pte_check_unit
  import pte_chk_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int UPPER_W = 10,
  parameter int PPN_LSB = 10,
  localparam int PPN_W = ENTRY_W - UPPER_W - PPN_LSB
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [ENTRY_W-1:0] entryIn,
  input  logic [1:0]         modeSel,
  input  logic [1:0]         accKind,
  input  logic [1:0]         privLvl,
  input  logic               mxrBit,
  input  logic               sumBit,
  output logic               outValid,
  input  logic               outReady,
  output logic               pageFault,
  output logic               isPointer,
  output logic               needWriteback,
  output logic               internalErr,
  output logic [ENTRY_W-1:0] entryOut,
  output logic [PPN_W-1:0]   ppnOut,
  output logic [UPPER_W-1:0] upperOut
);
  ctrlStrobe_t strobe;

  pte_chk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  pte_chk_dp #(.ENTRY_W(ENTRY_W), .UPPER_W(UPPER_W), .PPN_LSB(PPN_LSB)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .entryIn(entryIn),
    .modeSel(modeSel), .accKind(accKind), .privLvl(privLvl),
    .mxrBit(mxrBit), .sumBit(sumBit), .pageFault(pageFault),
    .isPointer(isPointer), .needWriteback(needWriteback),
    .internalErr(internalErr), .entryOut(entryOut), .ppnOut(ppnOut),
    .upperOut(upperOut)
  );
endmodule

// File: rtl/pte_check_unit_chk.sv
module pte_check_unit_chk #(
  parameter int ENTRY_W = 64,
  parameter int UPPER_W = 10,
  parameter int PPN_LSB = 10,
  localparam int PPN_W = ENTRY_W - UPPER_W - PPN_LSB
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inReady,
  input logic [ENTRY_W-1:0] entryIn,
  input logic [1:0]         modeSel,
  input logic               outValid,
  input logic               outReady,
  input logic               pageFault,
  input logic               isPointer,
  input logic               needWriteback,
  input logic               internalErr,
  input logic [ENTRY_W-1:0] entryOut,
  input logic [PPN_W-1:0]   ppnOut,
  input logic [UPPER_W-1:0] upperOut
);
  // R6
  machine_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && internalErr |-> !pageFault && !needWriteback);

  // R7
  wb_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && needWriteback |-> !pageFault && entryOut[6]);

  // R1
  pointer_no_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && isPointer |-> !pageFault && !needWriteback);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(entryOut) && $stable(pageFault)
      && $stable(ppnOut));

  // R8
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  // R7
  high_bits_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> entryOut[ENTRY_W-1:8] == $past(entryIn[ENTRY_W-1:8]));

  // R2
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && modeSel == 2'd0 |=> upperOut == '0);
endmodule

bind pte_check_unit pte_check_unit_chk #(.ENTRY_W(ENTRY_W), .UPPER_W(UPPER_W),
  .PPN_LSB(PPN_LSB)) chk_i (.*);

// File: tb/pte_check_unit_tb_top.sv
`timescale 1ns/1ps
module pte_check_unit_tb_top;
  typedef struct packed {
    logic        pf;
    logic        ptr;
    logic        wb;
    logic        ie;
    logic [63:0] eo;
    logic [43:0] ppn;
    logic [9:0]  up;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [63:0] entryIn = '0;
  logic [1:0] modeSel = '0, accKind = '0, privLvl = '0;
  logic mxrBit = 1'b0, sumBit = 1'b0, outReady = 1'b1;
  logic inReady, outValid, pageFault, isPointer, needWriteback, internalErr;
  logic [63:0] entryOut;
  logic [43:0] ppnOut;
  logic [9:0]  upperOut;
  int total = 0, bad = 0;
  int stallMode = 0;
  bit finished = 0;
  logic mValid;
  exp_t mExp;

  always #2.5 clk = ~clk;

  pte_check_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .entryIn(entryIn), .modeSel(modeSel), .accKind(accKind),
    .privLvl(privLvl), .mxrBit(mxrBit), .sumBit(sumBit),
    .outValid(outValid), .outReady(outReady), .pageFault(pageFault),
    .isPointer(isPointer), .needWriteback(needWriteback),
    .internalErr(internalErr), .entryOut(entryOut), .ppnOut(ppnOut),
    .upperOut(upperOut)
  );

  function automatic exp_t refModel(input logic [63:0] e, input logic [1:0] m,
      input logic [1:0] a, input logic [1:0] p, input logic mx, input logic su);
    exp_t r;
    logic ok, wr, rd, sane;
    wr   = (a == 2'd1) || (a == 2'd2);
    rd   = e[1] || (e[3] && mx);
    sane = e[0] && !(e[2] && !e[1]);
    r.ie  = (p >= 2'd2);
    r.ptr = sane && !e[1] && !e[2] && !e[3];
    ok = 1'b0;
    if (p == 2'd0) begin
      if (a == 2'd0) ok = e[4] && rd;
      else if (a == 2'd1) ok = e[4] && e[2];
      else if (a == 2'd2) ok = e[4] && e[2] && rd;
      else ok = e[4] && e[3];
    end else if (p == 2'd1) begin
      if (a == 2'd3) ok = !e[4] && e[3];
      else if (a == 2'd0) ok = (!e[4] || su) && rd;
      else if (a == 2'd1) ok = (!e[4] || su) && e[2];
      else ok = (!e[4] || su) && e[2] && rd;
    end
    r.pf = !r.ie && (!sane || (!r.ptr && !ok));
    r.wb = !r.ie && !r.pf && !r.ptr && (!e[6] || (!e[7] && wr));
    r.eo = e;
    if (r.wb) begin
      r.eo[6] = 1'b1;
      if (wr) r.eo[7] = 1'b1;
    end
    if (m == 2'd0) begin
      r.ppn = {22'd0, e[31:10]};
      r.up  = '0;
    end else begin
      r.ppn = e[53:10];
      r.up  = e[63:54];
    end
    return r;
  endfunction

  // cycle model of the output stage
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mValid <= 1'b0;
      mExp   <= '0;
    end else if (inValid && (!mValid || outReady)) begin
      mValid <= 1'b1;
      mExp   <= refModel(entryIn, modeSel, accKind, privLvl, mxrBit, sumBit);
    end else if (outReady) begin
      mValid <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act,
      input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check(outValid === mValid, "R8 R9 outValid", 64'(outValid), 64'(mValid));
      check(inReady === (!mValid || outReady), "R8 inReady", 64'(inReady),
            64'(!mValid || outReady));
      if (mValid && outValid) begin
        check(pageFault === mExp.pf, "R1 R3 R4 R5 pageFault", 64'(pageFault), 64'(mExp.pf));
        check(isPointer === mExp.ptr, "R1 isPointer", 64'(isPointer), 64'(mExp.ptr));
        check(needWriteback === mExp.wb, "R7 needWriteback", 64'(needWriteback), 64'(mExp.wb));
        check(internalErr === mExp.ie, "R6 internalErr", 64'(internalErr), 64'(mExp.ie));
        check(entryOut === mExp.eo, "R7 entryOut", entryOut, mExp.eo);
        check(ppnOut === mExp.ppn, "R2 ppnOut", 64'(ppnOut), 64'(mExp.ppn));
        check(upperOut === mExp.up, "R2 upperOut", 64'(upperOut), 64'(mExp.up));
      end
    end
  end

  function automatic logic pickReady();
    if (stallMode == 0) return 1'b1;
    return ($urandom % 3) != 0;
  endfunction

  task automatic sendOne(input logic [63:0] e, input logic [1:0] m, input logic [1:0] a,
      input logic [1:0] p, input logic mx, input logic su);
    @(negedge clk); #1;
    entryIn = e; modeSel = m; accKind = a; privLvl = p;
    mxrBit = mx; sumBit = su; inValid = 1'b1; outReady = pickReady();
    while (!inReady) begin
      @(negedge clk); #1;
      outReady = pickReady();
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1;
    inValid = 1'b0; outReady = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  localparam logic [63:0] BASE = 64'hA5C3_1234_5678_9A00;

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(outValid === 1'b0, "R9 reset outValid", 64'(outValid), 64'd0);
    #1 rstN = 1'b1;
    idle(2);
    // R1 broken and pointer entries
    sendOne(BASE | 64'h00, 2'd1, 2'd0, 2'd1, 0, 0);
    sendOne(BASE | 64'h05, 2'd1, 2'd0, 2'd1, 0, 0);
    sendOne(BASE | 64'h01, 2'd2, 2'd0, 2'd0, 0, 0);
    // R3 user rules
    sendOne(BASE | 64'h53, 2'd0, 2'd0, 2'd0, 0, 0);
    sendOne(BASE | 64'h59, 2'd0, 2'd0, 2'd0, 0, 0);
    sendOne(BASE | 64'h59, 2'd0, 2'd0, 2'd0, 1, 0);
    sendOne(BASE | 64'hD3, 2'd1, 2'd1, 2'd0, 0, 0);
    sendOne(BASE | 64'h57, 2'd1, 2'd2, 2'd0, 0, 0);
    sendOne(BASE | 64'h5D, 2'd2, 2'd2, 2'd0, 1, 0);
    sendOne(BASE | 64'h59, 2'd2, 2'd3, 2'd0, 0, 0);
    sendOne(BASE | 64'h4B, 2'd2, 2'd0, 2'd0, 0, 0);
    // R4 supervisor and SUM
    sendOne(BASE | 64'h57, 2'd1, 2'd0, 2'd1, 0, 0);
    sendOne(BASE | 64'h57, 2'd1, 2'd0, 2'd1, 0, 1);
    sendOne(BASE | 64'h47, 2'd1, 2'd1, 2'd1, 0, 0);
    // R5 supervisor execute
    sendOne(BASE | 64'h59, 2'd1, 2'd3, 2'd1, 0, 1);
    sendOne(BASE | 64'h49, 2'd1, 2'd3, 2'd1, 0, 1);
    // R6 machine
    sendOne(BASE | 64'h0F, 2'd1, 2'd0, 2'd3, 0, 0);
    sendOne(BASE | 64'h00, 2'd0, 2'd1, 2'd2, 0, 0);
    // R7 accessed/dirty
    sendOne(BASE | 64'hC7, 2'd1, 2'd1, 2'd1, 0, 0);
    sendOne(BASE | 64'h47, 2'd1, 2'd0, 2'd1, 0, 0);
    sendOne(BASE | 64'h07, 2'd1, 2'd0, 2'd1, 0, 0);
    sendOne(BASE | 64'h07, 2'd2, 2'd1, 2'd1, 0, 0);
    sendOne(BASE | 64'h87, 2'd2, 2'd2, 2'd1, 0, 0);
    // R2 modes with an all-ones high half
    sendOne(64'hFFFF_FFFF_8765_4C0F, 2'd0, 2'd0, 2'd1, 0, 0);
    sendOne(64'hFFFF_FFFF_8765_4C0F, 2'd3, 2'd0, 2'd1, 0, 0);
    idle(3);
    // R8 random traffic with stalls
    stallMode = 1;
    for (int i = 0; i < 600; i++) begin
      sendOne({$urandom, $urandom}, 2'($urandom), 2'($urandom), 2'($urandom),
              1'($urandom), 1'($urandom));
      if (i % 37 == 0) idle(2);
    end
    stallMode = 0;
    idle(4);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule